// File: doc/BRIEF.md
# Peak-Driven Front-End Gain Controller

This block sits beside a direct-sampling receiver's ADC and steers the code of a front-end attenuator or amplifier. It takes the magnitude of every valid signed sample and tracks the largest magnitude seen inside a measurement window. The window length is a programmable count of valid samples, typically set to about one second of sample clocks. When a window closes, the block compares that window's peak with two power-of-two fractions of full scale. A peak above one quarter of full scale lowers the gain code by one. A peak at or below one sixteenth raises it by one. Anything in between leaves the code alone. A change is at most one step per window, and the code never moves past host-set limits, so one isolated clip cannot cause a large swing.

A second register keeps a high-water mark for the host: the largest magnitude seen since the host last read it. A read strobe empties it. This mark runs apart from the window peak. The host can watch headroom over any interval it likes, and windows closing do not disturb it. A one-cycle change pulse goes with every new gain code, so downstream logic can correct level readings.

Top module: `pkgain_ctrl`

## Requirements
- R1: The magnitude of a sample is its absolute value as an unsigned SAMPLE_W-bit number. The most negative code, -2^(SAMPLE_W-1), has magnitude 2^(SAMPLE_W-1), which is full scale.
- R2: A window holds `win_len` valid samples. `gain_code` holds its value through the first `win_len`-1 samples. Any update appears on the clock edge that takes in the window's last sample, and that last sample counts toward the window's peak.
- R3: When a window's peak is strictly greater than 2^(SAMPLE_W-3) (one quarter of full scale), `gain_code` falls by one, unless it is already at or below `gain_min`.
- R4: When a window's peak is less than or equal to 2^(SAMPLE_W-5) (one sixteenth of full scale), `gain_code` rises by one, unless it is already at or above `gain_max`.
- R5: A peak above one sixteenth and at or below one quarter of full scale leaves `gain_code` unchanged. For example, peaks of exactly 2^(SAMPLE_W-3) and of 2^(SAMPLE_W-5)+1 both hold the code.
- R6: `gain_code` moves by at most one per window, whatever the number of samples past a threshold. The window peak starts again from zero for each new window.
- R7: `gain_chg` is high for exactly the one cycle in which a new `gain_code` value first appears, and low in every other cycle.
- R8: `hwm` shows the largest magnitude seen since the last read. When `hwm_rd` is high on an edge, `hwm` becomes that cycle's valid sample magnitude, or 0 if the cycle has no valid sample.
- R9: The close of a window has no effect on `hwm`.
- R10: After reset, `gain_code` equals GAIN_RESET, `gain_chg` is 0, `hwm` is 0, and the window count starts from zero.
- R11: A cycle with `smp_valid` low changes nothing: not the window count, not the window peak, and not `hwm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Qualifies `smp_data` this cycle |
| smp_data | input | SAMPLE_W | Signed two's-complement ADC sample |
| win_len | input | WIN_W | Number of valid samples in each window |
| gain_min | input | GAIN_W | Lowest code a downward step may reach |
| gain_max | input | GAIN_W | Highest code an upward step may reach |
| hwm_rd | input | 1 | Host read strobe; empties the high-water mark |
| gain_code | output | GAIN_W | Front-end gain code; larger means more gain |
| gain_chg | output | 1 | One-cycle pulse on each new gain code |
| hwm | output | SAMPLE_W | Largest magnitude since the last read |

## Verification
The clocked properties assume `gain_min` and `gain_max` stay steady from one edge to the next around a window close. They also assume GAIN_RESET lies inside the limits, so an upward step can never wrap the code. The stimulus changes the limits only between windows, never in the cycle a window's last sample arrives. It keeps `win_len` at a small nonzero value. `smp_valid` and `hwm_rd` are driven freely, including reads in the same cycle as a sample and read cycles with no valid sample.

// File: rtl/pkgain_pkg.sv
package pkgain_pkg;

    // Decision taken when a measurement window closes.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2
    } step_e;

endpackage

// File: rtl/pkgain_mag.sv
module pkgain_mag #(
    parameter int SAMPLE_W = 14
) (
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [SAMPLE_W-1:0] smp_mag
);

    // Two's-complement absolute value; the most negative code maps to 2^(N-1).
    always_comb begin
        if (smp_data[SAMPLE_W-1]) begin
            smp_mag = ~smp_data + 1'b1;
        end else begin
            smp_mag = smp_data;
        end
    end

endmodule

// File: rtl/pkgain_win.sv
module pkgain_win #(
    parameter int WIN_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [WIN_W-1:0] win_len,
    output logic             win_end
);

    typedef struct packed {
        logic [WIN_W-1:0] cnt;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [WIN_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        win_end = smp_valid && (cnt_inc >= {1'b0, win_len});
        if (smp_valid) begin
            st_d.cnt = win_end ? '0 : cnt_inc[WIN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pkgain_peak.sv
module pkgain_peak #(
    parameter int MAG_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [MAG_W-1:0] smp_mag,
    input  logic             win_end,
    input  logic             hwm_rd,
    output logic [MAG_W-1:0] win_peak,
    output logic [MAG_W-1:0] hwm
);

    typedef struct packed {
        logic [MAG_W-1:0] peak;
        logic [MAG_W-1:0] mark;
    } peak_st_t;

    peak_st_t st_d, st_q;
    logic [MAG_W-1:0] vld_mag;

    always_comb begin
        st_d    = st_q;
        vld_mag = smp_valid ? smp_mag : '0;

        // Window peak including the current sample; evaluated at the close.
        win_peak = (vld_mag > st_q.peak) ? vld_mag : st_q.peak;
        st_d.peak = win_end ? '0 : win_peak;

        // Host mark: restart on read, otherwise keep the larger value.
        if (hwm_rd) begin
            st_d.mark = vld_mag;
        end else if (vld_mag > st_q.mark) begin
            st_d.mark = vld_mag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hwm = st_q.mark;

endmodule

// File: rtl/pkgain_step.sv
module pkgain_step #(
    parameter int MAG_W      = 14,
    parameter int GAIN_W     = 5,
    parameter int GAIN_RESET = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_end,
    input  logic [MAG_W-1:0]  win_peak,
    input  logic [GAIN_W-1:0] gain_min,
    input  logic [GAIN_W-1:0] gain_max,
    output logic [GAIN_W-1:0] gain_code,
    output logic              gain_chg
);

    localparam logic [MAG_W-1:0] QTR_LVL = {{(MAG_W-1){1'b0}}, 1'b1} << (MAG_W - 3);
    localparam logic [MAG_W-1:0] SIX_LVL = {{(MAG_W-1){1'b0}}, 1'b1} << (MAG_W - 5);
    localparam logic [GAIN_W-1:0] CODE_RST = GAIN_W'(GAIN_RESET);

    typedef struct packed {
        logic [GAIN_W-1:0] code;
        logic              chg;
    } step_st_t;

    step_st_t st_d, st_q;
    pkgain_pkg::step_e dec;

    always_comb begin
        if (win_peak > QTR_LVL) begin
            dec = pkgain_pkg::STEP_DOWN;
        end else if (win_peak <= SIX_LVL) begin
            dec = pkgain_pkg::STEP_UP;
        end else begin
            dec = pkgain_pkg::STEP_HOLD;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (win_end) begin
            if (dec == pkgain_pkg::STEP_DOWN && st_q.code > gain_min) begin
                st_d.code = st_q.code - 1'b1;
                st_d.chg  = 1'b1;
            end else if (dec == pkgain_pkg::STEP_UP && st_q.code < gain_max) begin
                st_d.code = st_q.code + 1'b1;
                st_d.chg  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= CODE_RST;
            st_q.chg  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain_code = st_q.code;
    assign gain_chg  = st_q.chg;

endmodule

// File: rtl/pkgain_ctrl.sv
module pkgain_ctrl #(
    parameter int SAMPLE_W   = 14,
    parameter int GAIN_W     = 5,
    parameter int WIN_W      = 27,
    parameter int GAIN_RESET = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [WIN_W-1:0]    win_len,
    input  logic [GAIN_W-1:0]   gain_min,
    input  logic [GAIN_W-1:0]   gain_max,
    input  logic                hwm_rd,
    output logic [GAIN_W-1:0]   gain_code,
    output logic                gain_chg,
    output logic [SAMPLE_W-1:0] hwm
);

    logic [SAMPLE_W-1:0] smp_mag;
    logic [SAMPLE_W-1:0] win_peak;
    logic                win_end;

    pkgain_mag #(.SAMPLE_W(SAMPLE_W)) mag_i (
        .smp_data (smp_data),
        .smp_mag  (smp_mag)
    );

    pkgain_win #(.WIN_W(WIN_W)) win_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .win_len   (win_len),
        .win_end   (win_end)
    );

    pkgain_peak #(.MAG_W(SAMPLE_W)) peak_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_mag   (smp_mag),
        .win_end   (win_end),
        .hwm_rd    (hwm_rd),
        .win_peak  (win_peak),
        .hwm       (hwm)
    );

    pkgain_step #(
        .MAG_W      (SAMPLE_W),
        .GAIN_W     (GAIN_W),
        .GAIN_RESET (GAIN_RESET)
    ) step_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end   (win_end),
        .win_peak  (win_peak),
        .gain_min  (gain_min),
        .gain_max  (gain_max),
        .gain_code (gain_code),
        .gain_chg  (gain_chg)
    );

endmodule

// File: rtl/pkgain_ctrl_chk.sv
module pkgain_ctrl_chk #(
    parameter int SAMPLE_W = 14,
    parameter int GAIN_W   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic                hwm_rd,
    input logic [GAIN_W-1:0]   gain_min,
    input logic [GAIN_W-1:0]   gain_max,
    input logic [GAIN_W-1:0]   gain_code,
    input logic                gain_chg,
    input logic [SAMPLE_W-1:0] hwm
);

    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_code) |->
            (gain_code == $past(gain_code) + 1'b1) || (gain_code == $past(gain_code) - 1'b1));

    p_pulse_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_code) |-> gain_chg);

    p_pulse_only_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gain_chg |-> !$stable(gain_code));

    p_floor_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_chg && gain_code < $past(gain_code)) |-> gain_code >= $past(gain_min));

    p_ceiling_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_chg && gain_code > $past(gain_code)) |-> gain_code <= $past(gain_max));

    p_step_needs_sample_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gain_chg |-> $past(smp_valid));

    p_mark_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hwm_rd) |-> hwm >= $past(hwm));

    p_idle_mark_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!smp_valid && !hwm_rd) |-> $stable(hwm));

endmodule

bind pkgain_ctrl pkgain_ctrl_chk #(
    .SAMPLE_W (SAMPLE_W),
    .GAIN_W   (GAIN_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .hwm_rd    (hwm_rd),
    .gain_min  (gain_min),
    .gain_max  (gain_max),
    .gain_code (gain_code),
    .gain_chg  (gain_chg),
    .hwm       (hwm)
);

// File: tb/pkgain_ctrl_tb_top.sv
`timescale 1ns/1ps
module pkgain_ctrl_tb_top;

    localparam int SW = 14;
    localparam int GW = 5;
    localparam int WW = 27;
    localparam int WL = 4;
    localparam int QTR = 2048;
    localparam int SIX = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [WW-1:0] win_len = WW'(WL);
    logic [GW-1:0] gain_min = '0;
    logic [GW-1:0] gain_max = 5'd31;
    logic          hwm_rd = 1'b0;
    logic [GW-1:0] gain_code;
    logic          gain_chg;
    logic [SW-1:0] hwm;

    int n_cmp = 0;
    int n_bad = 0;
    int g_exp = 16;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pkgain_ctrl #(.SAMPLE_W(SW), .GAIN_W(GW), .WIN_W(WW), .GAIN_RESET(16)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .win_len   (win_len),
        .gain_min  (gain_min),
        .gain_max  (gain_max),
        .hwm_rd    (hwm_rd),
        .gain_code (gain_code),
        .gain_chg  (gain_chg),
        .hwm       (hwm)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic tick(input int d, input logic v, input logic rd);
        @(negedge clk);
        smp_data  = SW'(d);
        smp_valid = v;
        hwm_rd    = rd;
        @(posedge clk);
        #1;
    endtask

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // Sends WL-1 copies of v_other then v_last; predicts the step from the thresholds.
    task automatic send_window(input int v_other, input int v_last, input string req);
        int pk;
        int chg_exp;
        for (int i = 0; i < WL - 1; i++) begin
            tick(v_other, 1'b1, 1'b0);
            chk({req, " R2 gain held inside window"}, gain_code, g_exp);
            chk({req, " R7 no pulse inside window"}, gain_chg, 0);
        end
        tick(v_last, 1'b1, 1'b0);
        pk = (iabs(v_other) > iabs(v_last)) ? iabs(v_other) : iabs(v_last);
        chg_exp = 0;
        if (pk > QTR && g_exp > gain_min) begin
            g_exp--;
            chg_exp = 1;
        end else if (pk <= SIX && g_exp < gain_max) begin
            g_exp++;
            chg_exp = 1;
        end
        chk({req, " gain at window close"}, gain_code, g_exp);
        chk({req, " R7 pulse at window close"}, gain_chg, chg_exp);
        tick(0, 1'b0, 1'b0);
        chk({req, " R7 pulse lasts one cycle"}, gain_chg, 0);
        chk({req, " gain after close"}, gain_code, g_exp);
    endtask

    task automatic t_reset();
        chk("R10 gain reset value", gain_code, 16);
        chk("R10 pulse low in reset", gain_chg, 0);
        chk("R10 mark empty", hwm, 0);
    endtask

    task automatic t_down();
        send_window(100, -3000, "R3 R1 over quarter");
    endtask

    task automatic t_up();
        send_window(512, -512, "R4 at sixteenth");
    endtask

    task automatic t_hold();
        send_window(100, 2048, "R5 exactly quarter");
        send_window(513, -513, "R5 just over sixteenth");
    endtask

    task automatic t_single_step();
        send_window(8191, -8192, "R6 all samples clipping");
        send_window(100, 100, "R6 peak cleared next window");
    endtask

    task automatic t_invalid();
        for (int i = 0; i < 3; i++) begin
            tick(8000, 1'b0, 1'b0);
            chk("R11 idle cycle gain", gain_code, g_exp);
        end
        send_window(50, 50, "R11 idle cycles not counted");
    endtask

    task automatic t_clamp();
        gain_max = GW'(g_exp);
        send_window(50, 50, "R4 ceiling");
        gain_min = GW'(g_exp);
        send_window(5000, 5000, "R3 floor");
        gain_min = '0;
        gain_max = 5'd31;
    endtask

    task automatic t_mark();
        tick(0, 1'b0, 1'b1);
        chk("R8 read empties mark", hwm, 0);
        tick(700, 1'b1, 1'b0);
        chk("R8 mark first sample", hwm, 700);
        tick(-900, 1'b1, 1'b0);
        chk("R8 mark larger negative", hwm, 900);
        tick(300, 1'b1, 1'b0);
        chk("R8 mark keeps max", hwm, 900);
        tick(100, 1'b1, 1'b0);
        chk("R9 window close leaves mark", hwm, 900);
        chk("R5 window of 900 holds gain", gain_code, g_exp);
        tick(50, 1'b1, 1'b1);
        chk("R8 read with sample restarts mark", hwm, 50);
        tick(-8192, 1'b1, 1'b0);
        chk("R1 most negative magnitude", hwm, 8192);
        tick(0, 1'b0, 1'b1);
        chk("R8 read without sample", hwm, 0);
        tick(8000, 1'b0, 1'b0);
        chk("R11 idle sample not marked", hwm, 0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_down();
        t_up();
        t_hold();
        t_single_step();
        t_invalid();
        t_clamp();
        t_mark();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule